// File: doc/BRIEF.md
# Host Interrupt Status and Mask Unit

This block gathers a set of single-bit interrupt sources from inside the device, latches each rising edge into a sticky status bit, and raises one host interrupt line whenever a latched bit is not masked. A host reaches the mask and the status through a small register bus. Six addresses act on the same two registers: the mask can be written whole, have bits set, or have bits cleared; the status can be read without side effects, read and cleared at once, or have single bits acknowledged.

Each source is latched regardless of its mask, so the host can poll masked events and unmask them later without losing them. The host line is registered, and a configuration input selects whether it is active high or active low. The source positions fixed by the device are: receive buffers 0 and 1 data at bits 0 and 3; transmit data at bit 1 and transmit transfer at bit 2; receive transfer at bit 4; event mailboxes A and B at bits 5 and 6; wake at bit 7; trace A and B at bits 8 and 9; command complete at bit 10; initialization complete at bit 14; coexistence sense enable and disable at bits 16 and 17.

Top module: `host_int_ctrl`

## Requirements
- R1: During and after a reset the mask holds 0x0001, every status bit is 0, bus_rdata_o is 0 and host_irq_o sits at its inactive level (equal to cfg_active_low_i).
- R2: A 0-to-1 change of src_i[i] sets status bit i at the next clock edge whether or not mask bit i is set; a source held high does not set the bit again after it was cleared. A source already high when reset ends counts as a rising edge.
- R3: A write to address 0 replaces the mask with the low NUM_SRC bits of bus_wdata_i; a read of address 0 returns the mask with all higher bits 0.
- R4: A write to address 1 sets each mask bit whose bus_wdata_i bit is 1 and leaves the others unchanged.
- R5: A write to address 2 clears each mask bit whose bus_wdata_i bit is 1 and leaves the others unchanged.
- R6: A read of address 3 returns the status and leaves it unchanged.
- R7: A read of address 4 returns the status as it was before the read and clears every status bit.
- R8: A write to address 5 clears each status bit whose bus_wdata_i bit is 1; 0 bits have no effect.
- R9: When a rising edge and a clear (by address 4 read or address 5 acknowledge) hit the same bit in the same cycle, the bit ends up set.
- R10: One cycle after the status and mask change, host_irq_o equals NOT cfg_active_low_i when some status bit has mask bit 0, and equals cfg_active_low_i otherwise.
- R11: Reads of addresses 1, 2 and 5 return 0; writes to addresses 3 and 4 change nothing. Read data appears on bus_rdata_o one cycle after the read is sampled and is 0 in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt sources, rising edge triggered |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| cfg_active_low_i | input | 1 | 1 selects an active-low host line |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
The bench aims at the same-cycle collisions: an edge arriving with an acknowledge or a clear-on-read of the same bit, where a design that gave the clear priority would drop an event for good, and a clear-on-read that returned post-clear data would hand the host zero. It holds a source high across a clear to catch a level-sensitive latch that would re-fire forever, and checks that masked events are still latched so that unmasking raises the line. It flips polarity and re-resets in active-low mode, where a reset value of 0 would assert the line spuriously, and writes all ones to the mask to catch leaks into unused read bits.

// File: rtl/hint_pkg.sv
package hint_pkg;

   // Register bus addresses
   typedef enum logic [2:0] {
      HA_MASK      = 3'd0,
      HA_MASK_SET  = 3'd1,
      HA_MASK_CLR  = 3'd2,
      HA_STAT_PEEK = 3'd3,
      HA_STAT_TAKE = 3'd4,
      HA_ACK       = 3'd5
   } hint_addr_e;

   // Source positions fixed by the device
   localparam int SRC_RXB0      = 0;
   localparam int SRC_TXDATA    = 1;
   localparam int SRC_TXXFER    = 2;
   localparam int SRC_RXB1      = 3;
   localparam int SRC_RXXFER    = 4;
   localparam int SRC_EVMBOX_A  = 5;
   localparam int SRC_EVMBOX_B  = 6;
   localparam int SRC_WAKE      = 7;
   localparam int SRC_TRACE_A   = 8;
   localparam int SRC_TRACE_B   = 9;
   localparam int SRC_CMD_DONE  = 10;
   localparam int SRC_INIT_DONE = 14;
   localparam int SRC_COEX_ON   = 16;
   localparam int SRC_COEX_OFF  = 17;
   localparam int SRC_COUNT     = 18;

endpackage

// File: rtl/hint_edge.sv
module hint_edge #(
   parameter int N = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   output logic [N-1:0] rise_o
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= src_i;
   end

   assign rise_o = src_i & ~prev_q;

endmodule

// File: rtl/hint_mask_reg.sv
module hint_mask_reg #(
   parameter int           N       = 18,
   parameter logic [N-1:0] RST_VAL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_dir_i,
   input  logic         wr_set_i,
   input  logic         wr_clr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] mask_o
);
   logic [N-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        mask_q <= RST_VAL;
      else if (wr_dir_i) mask_q <= wdata_i;
      else if (wr_set_i) mask_q <= mask_q | wdata_i;
      else if (wr_clr_i) mask_q <= mask_q & ~wdata_i;
   end

   assign mask_o = mask_q;

   // R3
   mask_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_i |=> mask_q == $past(wdata_i));

   // R4
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set_i && !wr_dir_i) |=> (mask_q & $past(wdata_i)) == $past(wdata_i));

   // R5
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr_i && !wr_dir_i && !wr_set_i) |=> (mask_q & $past(wdata_i)) == '0);

endmodule

// File: rtl/hint_status_reg.sv
module hint_status_reg #(
   parameter int N = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rise_i,
   input  logic         clr_all_i,
   input  logic [N-1:0] ack_i,
   output logic [N-1:0] stat_o
);
   logic [N-1:0] stat_q;

   for (genvar gi = 0; gi < N; gi++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                      stat_q[gi] <= 1'b0;
         else if (rise_i[gi])             stat_q[gi] <= 1'b1;
         else if (clr_all_i || ack_i[gi]) stat_q[gi] <= 1'b0;
      end

      // R2, R9
      edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rise_i[gi] |=> stat_q[gi]);

      // R8
      ack_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i[gi] && !rise_i[gi]) |=> !stat_q[gi]);
   end

   assign stat_o = stat_q;

   // R7
   take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all_i && rise_i == '0) |=> stat_q == '0);

endmodule

// File: rtl/hint_line_drv.sv
module hint_line_drv #(
   parameter int N = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] stat_i,
   input  logic [N-1:0] mask_i,
   input  logic         active_low_i,
   output logic         irq_o
);
   logic pend;
   logic irq_q;

   assign pend = |(stat_i & ~mask_i);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= active_low_i;
      else        irq_q <= pend ^ active_low_i;
   end

   assign irq_o = irq_q;

   // R10
   line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_i & ~mask_i) == '0) |=> irq_o == $past(active_low_i));

   // R10
   line_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_i & ~mask_i) != '0) |=> irq_o != $past(active_low_i));

endmodule

// File: rtl/host_int_ctrl.sv
module host_int_ctrl
   import hint_pkg::*;
#(
   parameter int                  NUM_SRC  = SRC_COUNT,
   parameter int                  DATA_W   = 32,
   parameter int                  ADDR_W   = 3,
   parameter logic [NUM_SRC-1:0]  MASK_RST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              cfg_active_low_i,
   output logic              host_irq_o
);
   localparam int PAD_W = DATA_W - NUM_SRC;

   initial begin
      assert (NUM_SRC >= 1 && NUM_SRC <= DATA_W);
      assert (ADDR_W >= 3);
   end

   logic [NUM_SRC-1:0] wval;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] stat;
   logic [NUM_SRC-1:0] rsel;
   logic [NUM_SRC-1:0] ack_bits;
   logic               a_mask, a_set, a_clr, a_peek, a_take, a_ack;
   logic               take_rd;
   logic [DATA_W-1:0]  rdata_q;

   assign wval = bus_wdata_i[NUM_SRC-1:0];

   if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^bus_wdata_i[DATA_W-1:NUM_SRC];
   end

   // address decode
   assign a_mask = bus_addr_i == ADDR_W'(HA_MASK);
   assign a_set  = bus_addr_i == ADDR_W'(HA_MASK_SET);
   assign a_clr  = bus_addr_i == ADDR_W'(HA_MASK_CLR);
   assign a_peek = bus_addr_i == ADDR_W'(HA_STAT_PEEK);
   assign a_take = bus_addr_i == ADDR_W'(HA_STAT_TAKE);
   assign a_ack  = bus_addr_i == ADDR_W'(HA_ACK);

   assign take_rd  = bus_rd_i && a_take;
   assign ack_bits = (bus_wr_i && a_ack) ? wval : '0;

   hint_edge #(.N(NUM_SRC)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .rise_o (rise)
   );

   hint_mask_reg #(.N(NUM_SRC), .RST_VAL(MASK_RST)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_dir_i (bus_wr_i && a_mask),
      .wr_set_i (bus_wr_i && a_set),
      .wr_clr_i (bus_wr_i && a_clr),
      .wdata_i  (wval),
      .mask_o   (mask)
   );

   hint_status_reg #(.N(NUM_SRC)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise),
      .clr_all_i (take_rd),
      .ack_i     (ack_bits),
      .stat_o    (stat)
   );

   hint_line_drv #(.N(NUM_SRC)) u_line (
      .clk          (clk),
      .rst_n        (rst_n),
      .stat_i       (stat),
      .mask_i       (mask),
      .active_low_i (cfg_active_low_i),
      .irq_o        (host_irq_o)
   );

   // read selection
   always_comb begin
      rsel = '0;
      if (bus_rd_i) begin
         if (a_mask)                rsel = mask;
         else if (a_peek || a_take) rsel = stat;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= DATA_W'(rsel);
   end

   assign bus_rdata_o = rdata_q;

   // R6
   peek_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && a_peek && !bus_wr_i && rise == '0) |=> $stable(stat));

   // R11
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && (a_set || a_clr || a_ack)) |=> bus_rdata_o == '0);

   // R11
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> bus_rdata_o == '0);

endmodule

// File: tb/sim_host_int_ctrl.sv
`timescale 1ns/1ps
module sim_host_int_ctrl;
   localparam int NS = 18;
   localparam int DW = 32;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          wr = 1'b0;
   logic          rd = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          cfg_lo = 1'b0;
   logic          irq;

   always #2 clk = ~clk;

   host_int_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk              (clk),
      .rst_n            (rst_n),
      .src_i            (src),
      .bus_wr_i         (wr),
      .bus_rd_i         (rd),
      .bus_addr_i       (addr),
      .bus_wdata_i      (wdata),
      .bus_rdata_o      (rdata),
      .cfg_active_low_i (cfg_lo),
      .host_irq_o       (irq)
   );

   typedef struct {
      logic [DW-1:0] val;
      string         req;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   logic rd_seen = 1'b0;

   task automatic chk(input logic ok, input string req,
                      input logic [DW-1:0] act, input logic [DW-1:0] expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) rd_seen <= rd && rst_n;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11 unexpected read", rdata, '0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rdata == e.val, e.req, rdata, e.val);
         end
      end
   end

   // driver tasks
   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         wr = 1'b0;
         rd = 1'b0;
      end
   endtask

   task automatic op(input logic w, input logic r, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [DW-1:0] e, input string req);
      exp_t x;
      @(negedge clk);
      wr = w; rd = r; addr = a; wdata = d;
      if (r) begin
         x.val = e; x.req = req;
         exp_q.push_back(x);
      end
   endtask

   task automatic rd_exp(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
      op(1'b0, 1'b1, a, '0, e, req);
      idle(1);
   endtask

   task automatic wr_do(input logic [AW-1:0] a, input logic [DW-1:0] d);
      op(1'b1, 1'b0, a, d, '0, "");
      idle(1);
   endtask

   task automatic set_src(input logic [NS-1:0] v);
      @(negedge clk);
      src = v; wr = 1'b0; rd = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string req);
      idle(3);
      chk(irq == e, req, DW'(irq), DW'(e));
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      idle(3);
      // R1: reset state
      chk(irq == 1'b0, "R1 irq in reset", DW'(irq), 0);
      chk(rdata == '0, "R1 rdata in reset", rdata, 0);
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      chk(irq == 1'b0, "R1 irq after reset", DW'(irq), 0);
      rd_exp(3'd0, 32'h1, "R1 mask reset");
      rd_exp(3'd3, 32'h0, "R1 status reset");

      // R2: masked source is still latched, line stays off
      set_src(18'h1);
      set_src(18'h0);
      chk_irq(1'b0, "R10 masked source");
      rd_exp(3'd3, 32'h1, "R2 masked edge latched");
      rd_exp(3'd3, 32'h1, "R6 peek unchanged");

      // R3: direct mask write unmasks
      wr_do(3'd0, 32'h0);
      chk_irq(1'b1, "R10 unmasked pending");
      rd_exp(3'd0, 32'h0, "R3 mask direct");

      // R8: acknowledge bit 0
      wr_do(3'd5, 32'h1);
      rd_exp(3'd3, 32'h0, "R8 ack clears");
      chk_irq(1'b0, "R8 line drops after ack");

      // R4 / R5: set and clear aliases
      wr_do(3'd1, 32'h6);
      wr_do(3'd1, 32'h100);
      rd_exp(3'd0, 32'h106, "R4 mask set");
      wr_do(3'd2, 32'h4);
      rd_exp(3'd0, 32'h102, "R5 mask clear");

      // R2 / R10: two sources, one masked
      set_src(18'h22);
      rd_exp(3'd3, 32'h22, "R2 two edges");
      chk_irq(1'b1, "R10 unmasked bit 5");

      // R7: clear on read, held level does not refire
      rd_exp(3'd4, 32'h22, "R7 take returns old");
      rd_exp(3'd3, 32'h0, "R7 take cleared");
      idle(2);
      rd_exp(3'd3, 32'h0, "R2 held level no refire");
      chk_irq(1'b0, "R7 line drops");

      // R9: edge with acknowledge in the same cycle
      set_src(18'h0);
      @(negedge clk);
      src = 18'h20; wr = 1'b1; rd = 1'b0; addr = 3'd5; wdata = 32'h20;
      idle(1);
      rd_exp(3'd3, 32'h20, "R9 edge beats ack");
      // R9: edge with clear-on-read in the same cycle
      op(1'b0, 1'b1, 3'd4, '0, 32'h20, "R9 take returns old");
      src = 18'h28;
      idle(1);
      rd_exp(3'd3, 32'h8, "R9 edge beats take");

      // R11: status aliases ignore writes, write-only aliases read zero
      wr_do(3'd3, 32'hFFFF);
      wr_do(3'd4, 32'hFFFF);
      rd_exp(3'd3, 32'h8, "R11 status write ignored");
      rd_exp(3'd0, 32'h102, "R11 mask untouched");
      rd_exp(3'd1, 32'h0, "R11 set alias reads zero");
      rd_exp(3'd2, 32'h0, "R11 clear alias reads zero");
      rd_exp(3'd5, 32'h0, "R11 ack alias reads zero");

      // R10: polarity
      chk_irq(1'b1, "R10 active high asserted");
      @(negedge clk); cfg_lo = 1'b1;
      chk_irq(1'b0, "R10 active low asserted");
      wr_do(3'd5, 32'h8);
      chk_irq(1'b1, "R10 active low idle");

      // R1: reset in active-low mode
      @(negedge clk); rst_n = 1'b0; src = '0;
      idle(3);
      chk(irq == 1'b1, "R1 active low reset level", DW'(irq), 1);
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      rd_exp(3'd0, 32'h1, "R1 mask after re-reset");
      rd_exp(3'd3, 32'h0, "R1 status after re-reset");

      // R2 top bit, R3 width
      set_src(18'h20000);
      idle(1);
      rd_exp(3'd3, 32'h20000, "R2 top source bit");
      chk_irq(1'b0, "R10 active low top bit");
      wr_do(3'd0, 32'hFFFF_FFFF);
      rd_exp(3'd0, 32'h3FFFF, "R3 mask upper bits zero");
      chk_irq(1'b1, "R10 fully masked idle");

      idle(3);
      chk(exp_q.size() == 0, "R11 reads drained", DW'(exp_q.size()), 0);
      summary();
      $finish;
   end

endmodule